// File: doc/BRIEF.md
# Pin Range to Parent Line Translator

This block turns a pin number into the number of the downstream interrupt line that carries it. Translation comes from a small table of ranges. Each slot holds a first pin, a first parent line and a length. A pin inside a slot's range maps to the slot's first parent line plus the pin's distance from the slot's first pin. When ranges overlap, the slot with the lowest index decides. One reserved pin value stands for "this pin has no wake line". That value never translates, even when a range covers it.

The table is written once at initialization, one slot per write. Each accepted write starts a walk over every pin the new range covers. The walk issues one disable request per cycle, in ascending pin order, so that the consumer starts each pin in the disabled state. The load port stays busy for the whole walk. A write offered while the port is busy is dropped.

Queries are presented with a valid strobe. The answer is registered and appears one cycle later, as a result strobe, a hit flag and the translated line number.

Top module: `pin_range_xlate`

## Requirements
- R1: While reset is held and after its release, no slot is loaded, `res_valid`, `dis_valid` and `load_busy` are low, and every query misses.
- R2: `res_valid` is high exactly in the cycle after a cycle with `q_valid` high, and low otherwise; `res_hit` is never high without `res_valid`.
- R3: A pin matches a loaded slot when first_pin <= pin and pin < first_pin + length, with the sum taken one bit wider so that it cannot wrap; a slot of length 0 matches nothing.
- R4: On a hit, `res_parent` equals first_parent + (pin - first_pin), modulo 2^FIELD_W.
- R5: When several loaded slots match, the slot with the lowest index gives the result.
- R6: A query that matches no slot gives `res_hit` low and `res_parent` equal to 0.
- R7: A query of the reserved pin (default all ones) always gives `res_hit` low, even inside a loaded range.
- R8: A slot that has never been written cannot match.
- R9: An accepted write of length L > 0 makes `dis_valid` high for exactly L cycles, starting in the cycle after the write, with `dis_pin` running from first_pin upward by 1 each cycle; `load_busy` is high in those same cycles; a write of length 0 issues no request.
- R10: A write offered while `load_busy` is high changes neither the table nor the running walk.
- R11: Writing a slot that is already loaded replaces all three of its fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Slot write strobe, accepted only while not busy |
| wr_idx | input | IDX_W | Slot index to write |
| wr_pin_base | input | FIELD_W | First pin of the range |
| wr_parent_base | input | FIELD_W | First parent line of the range |
| wr_count | input | FIELD_W | Number of pins in the range |
| load_busy | output | 1 | Disable walk in progress; writes are dropped |
| q_valid | input | 1 | Query strobe |
| q_pin | input | FIELD_W | Pin to translate |
| res_valid | output | 1 | Result strobe, one cycle after the query |
| res_hit | output | 1 | Pin is connected |
| res_parent | output | FIELD_W | Translated parent line, 0 on a miss |
| dis_valid | output | 1 | Disable request for `dis_pin` |
| dis_pin | output | FIELD_W | Pin to start in the disabled state |

## Verification
The hardest cases to reach are the ones where the table's arithmetic meets its edges. These are a range that ends exactly at the top of the pin space and contains the reserved pin, a parent base near the top that wraps on the add, and overlapping ranges where only the slot order decides. Random pins would almost never land there. The stimulus therefore loads a fixed table built to create these cases, and then draws random queries mostly from windows around each range's ends, including the last few pin values. A write is also injected in the middle of a running walk. The bench then checks that the walk sequence is unchanged and that the target slot stays empty.

// File: rtl/pin_xlate_pkg.sv
package pin_xlate_pkg;

   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_RUN  = 1'b1
   } walk_state_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pin_xlate_table.sv
module pin_xlate_table #(
   parameter int unsigned N_ENTRIES = 4,
   parameter int unsigned FIELD_W   = 32,
   parameter int unsigned IDX_W     = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              load,
   input  logic [IDX_W-1:0]                  load_idx,
   input  logic [FIELD_W-1:0]                load_pin_base,
   input  logic [FIELD_W-1:0]                load_par_base,
   input  logic [FIELD_W-1:0]                load_count,
   output logic [N_ENTRIES-1:0]              slot_vld,
   output logic [N_ENTRIES-1:0][FIELD_W-1:0] slot_pin_base,
   output logic [N_ENTRIES-1:0][FIELD_W-1:0] slot_par_base,
   output logic [N_ENTRIES-1:0][FIELD_W-1:0] slot_count
);

   for (genvar s = 0; s < N_ENTRIES; s++) begin : g_slot
      logic sel;
      assign sel = load && (load_idx == IDX_W'(s));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_vld[s]      <= 1'b0;
            slot_pin_base[s] <= '0;
            slot_par_base[s] <= '0;
            slot_count[s]    <= '0;
         end else if (sel) begin
            slot_vld[s]      <= 1'b1;
            slot_pin_base[s] <= load_pin_base;
            slot_par_base[s] <= load_par_base;
            slot_count[s]    <= load_count;
         end
      end
   end

endmodule

// File: rtl/pin_xlate_match.sv
module pin_xlate_match #(
   parameter int unsigned N_ENTRIES    = 4,
   parameter int unsigned FIELD_W      = 32,
   parameter bit          USE_RESERVED = 1'b1,
   parameter logic [FIELD_W-1:0] RESERVED_PIN = '1
) (
   input  logic [FIELD_W-1:0]                pin,
   input  logic [N_ENTRIES-1:0]              slot_vld,
   input  logic [N_ENTRIES-1:0][FIELD_W-1:0] slot_pin_base,
   input  logic [N_ENTRIES-1:0][FIELD_W-1:0] slot_par_base,
   input  logic [N_ENTRIES-1:0][FIELD_W-1:0] slot_count,
   output logic                              hit,
   output logic [FIELD_W-1:0]                parent
);

   localparam int unsigned EXT_W = FIELD_W + 1;

   logic [N_ENTRIES-1:0]              in_range;
   logic [N_ENTRIES-1:0][FIELD_W-1:0] mapped;
   logic                              any_hit;
   logic [FIELD_W-1:0]                first_map;
   logic                              reserved;

   for (genvar s = 0; s < N_ENTRIES; s++) begin : g_cmp
      logic [EXT_W-1:0] pin_x, lo_x, hi_x;
      assign pin_x       = {1'b0, pin};
      assign lo_x        = {1'b0, slot_pin_base[s]};
      assign hi_x        = lo_x + {1'b0, slot_count[s]};
      assign in_range[s] = slot_vld[s] && (pin_x >= lo_x) && (pin_x < hi_x);
      assign mapped[s]   = slot_par_base[s] + (pin - slot_pin_base[s]);
   end

   // lowest index wins: scan from the top so the lowest match is written last
   always_comb begin
      any_hit   = 1'b0;
      first_map = '0;
      for (int s = N_ENTRIES - 1; s >= 0; s--) begin
         if (in_range[s]) begin
            any_hit   = 1'b1;
            first_map = mapped[s];
         end
      end
   end

   if (USE_RESERVED) begin : g_reserved
      assign reserved = (pin == RESERVED_PIN);
   end else begin : g_no_reserved
      assign reserved = 1'b0;
   end

   assign hit    = any_hit && !reserved;
   assign parent = hit ? first_map : '0;

endmodule

// File: rtl/pin_xlate_walker.sv
module pin_xlate_walker
   import pin_xlate_pkg::*;
#(
   parameter int unsigned FIELD_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FIELD_W-1:0] first_pin,
   input  logic [FIELD_W-1:0] length,
   output logic               busy,
   output logic [FIELD_W-1:0] cur_pin
);

   walk_state_e        state;
   logic [FIELD_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= WALK_IDLE;
         cur_pin <= '0;
         remain  <= '0;
      end else begin
         unique case (state)
            WALK_IDLE: begin
               if (start && (length != '0)) begin
                  state   <= WALK_RUN;
                  cur_pin <= first_pin;
                  remain  <= length;
               end
            end
            WALK_RUN: begin
               if (remain == FIELD_W'(1)) begin
                  state <= WALK_IDLE;
               end else begin
                  cur_pin <= cur_pin + FIELD_W'(1);
               end
               remain <= remain - FIELD_W'(1);
            end
            default: state <= WALK_IDLE;
         endcase
      end
   end

   assign busy = (state == WALK_RUN);

endmodule

// File: rtl/pin_range_xlate.sv
module pin_range_xlate
   import pin_xlate_pkg::*;
#(
   parameter int unsigned N_ENTRIES    = 4,
   parameter int unsigned FIELD_W      = 32,
   parameter bit          USE_RESERVED = 1'b1,
   parameter logic [FIELD_W-1:0] RESERVED_PIN = '1,
   localparam int unsigned IDX_W = idx_width(N_ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [FIELD_W-1:0] wr_pin_base,
   input  logic [FIELD_W-1:0] wr_parent_base,
   input  logic [FIELD_W-1:0] wr_count,
   output logic               load_busy,
   input  logic               q_valid,
   input  logic [FIELD_W-1:0] q_pin,
   output logic               res_valid,
   output logic               res_hit,
   output logic [FIELD_W-1:0] res_parent,
   output logic               dis_valid,
   output logic [FIELD_W-1:0] dis_pin
);

   if (N_ENTRIES < 1) begin : g_bad_entries
      $error("pin_range_xlate: N_ENTRIES must be at least 1");
   end
   if (FIELD_W < 2 || FIELD_W > 64) begin : g_bad_width
      $error("pin_range_xlate: FIELD_W must be within 2..64");
   end

   logic                              accept;
   logic                              walk_busy;
   logic [N_ENTRIES-1:0]              slot_vld;
   logic [N_ENTRIES-1:0][FIELD_W-1:0] slot_pin_base;
   logic [N_ENTRIES-1:0][FIELD_W-1:0] slot_par_base;
   logic [N_ENTRIES-1:0][FIELD_W-1:0] slot_count;
   logic                              m_hit;
   logic [FIELD_W-1:0]                m_parent;

   assign accept = wr_en && !walk_busy;

   pin_xlate_table #(
      .N_ENTRIES (N_ENTRIES),
      .FIELD_W   (FIELD_W),
      .IDX_W     (IDX_W)
   ) u_table (
      .clk           (clk),
      .rst_n         (rst_n),
      .load          (accept),
      .load_idx      (wr_idx),
      .load_pin_base (wr_pin_base),
      .load_par_base (wr_parent_base),
      .load_count    (wr_count),
      .slot_vld      (slot_vld),
      .slot_pin_base (slot_pin_base),
      .slot_par_base (slot_par_base),
      .slot_count    (slot_count)
   );

   pin_xlate_match #(
      .N_ENTRIES    (N_ENTRIES),
      .FIELD_W      (FIELD_W),
      .USE_RESERVED (USE_RESERVED),
      .RESERVED_PIN (RESERVED_PIN)
   ) u_match (
      .pin           (q_pin),
      .slot_vld      (slot_vld),
      .slot_pin_base (slot_pin_base),
      .slot_par_base (slot_par_base),
      .slot_count    (slot_count),
      .hit           (m_hit),
      .parent        (m_parent)
   );

   pin_xlate_walker #(
      .FIELD_W (FIELD_W)
   ) u_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .first_pin (wr_pin_base),
      .length    (wr_count),
      .busy      (walk_busy),
      .cur_pin   (dis_pin)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_hit    <= 1'b0;
         res_parent <= '0;
      end else begin
         res_valid  <= q_valid;
         res_hit    <= q_valid && m_hit;
         res_parent <= (q_valid && m_hit) ? m_parent : '0;
      end
   end

   assign load_busy = walk_busy;
   assign dis_valid = walk_busy;

endmodule

// File: rtl/pin_range_xlate_chk.sv
module pin_range_xlate_chk #(
   parameter int unsigned FIELD_W      = 32,
   parameter bit          USE_RESERVED = 1'b1,
   parameter logic [FIELD_W-1:0] RESERVED_PIN = '1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [FIELD_W-1:0] wr_pin_base,
   input logic [FIELD_W-1:0] wr_count,
   input logic               load_busy,
   input logic               q_valid,
   input logic [FIELD_W-1:0] q_pin,
   input logic               res_valid,
   input logic               res_hit,
   input logic [FIELD_W-1:0] res_parent,
   input logic               dis_valid,
   input logic [FIELD_W-1:0] dis_pin
);

   p_result_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |=> res_valid);

   p_no_spurious_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !q_valid |=> !res_valid);

   p_hit_has_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> res_valid);

   p_miss_reports_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_parent == '0));

   p_reserved_never_hits_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (USE_RESERVED && q_valid && (q_pin == RESERVED_PIN)) |=> !res_hit);

   p_walk_starts_at_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !load_busy && (wr_count != '0)) |=> (dis_valid && (dis_pin == $past(wr_pin_base))));

   p_walk_ascends_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_valid && $past(dis_valid)) |-> (dis_pin == $past(dis_pin) + FIELD_W'(1)));

   p_busy_matches_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load_busy == dis_valid);

   p_busy_write_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (load_busy && wr_en && dis_valid) |=> (!dis_valid || (dis_pin == $past(dis_pin) + FIELD_W'(1))));

endmodule

bind pin_range_xlate pin_range_xlate_chk #(
   .FIELD_W      (FIELD_W),
   .USE_RESERVED (USE_RESERVED),
   .RESERVED_PIN (RESERVED_PIN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_pin_base (wr_pin_base),
   .wr_count    (wr_count),
   .load_busy   (load_busy),
   .q_valid     (q_valid),
   .q_pin       (q_pin),
   .res_valid   (res_valid),
   .res_hit     (res_hit),
   .res_parent  (res_parent),
   .dis_valid   (dis_valid),
   .dis_pin     (dis_pin)
);

// File: tb/pin_range_xlate_tb_top.sv
`timescale 1ns/1ps
module pin_range_xlate_tb_top;

   localparam int unsigned N  = 4;
   localparam int unsigned W  = 32;
   localparam int unsigned IW = 2;
   localparam logic [W-1:0] RSV = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [IW-1:0] wr_idx = '0;
   logic [W-1:0]  wr_pin_base = '0, wr_parent_base = '0, wr_count = '0;
   logic          load_busy;
   logic          q_valid = 1'b0;
   logic [W-1:0]  q_pin = '0;
   logic          res_valid, res_hit, dis_valid;
   logic [W-1:0]  res_parent, dis_pin;

   int unsigned n_checks = 0;
   int unsigned n_bad = 0;

   // bench model of the table
   bit          m_vld [N];
   logic [W-1:0] m_base [N];
   logic [W-1:0] m_par  [N];
   logic [W-1:0] m_cnt  [N];

   always #10 clk = ~clk;   // 50 MHz

   pin_range_xlate #(.N_ENTRIES(N), .FIELD_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_pin_base(wr_pin_base),
      .wr_parent_base(wr_parent_base), .wr_count(wr_count),
      .load_busy(load_busy),
      .q_valid(q_valid), .q_pin(q_pin),
      .res_valid(res_valid), .res_hit(res_hit), .res_parent(res_parent),
      .dis_valid(dis_valid), .dis_pin(dis_pin)
   );

   task automatic check(input bit ok, input string req, input longint unsigned act,
                        input longint unsigned exp);
      n_checks++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic void model_query(input logic [W-1:0] p, output bit hit,
                                       output logic [W-1:0] par);
      hit = 1'b0;
      par = '0;
      if (p == RSV) return;                       // R7
      for (int s = 0; s < N; s++) begin           // R5 lowest slot first
         longint unsigned lo, hi, pp;
         lo = longint'(m_base[s]);
         hi = lo + longint'(m_cnt[s]);
         pp = longint'(p);
         if (m_vld[s] && pp >= lo && pp < hi) begin
            hit = 1'b1;
            par = W'((longint'(m_par[s]) + (pp - lo)) & 64'hFFFF_FFFF);
            return;
         end
      end
   endfunction

   task automatic do_query(input logic [W-1:0] p, input string tag);
      bit exp_hit;
      logic [W-1:0] exp_par;
      model_query(p, exp_hit, exp_par);
      @(posedge clk); #1;
      q_valid = 1'b1;
      q_pin   = p;
      @(posedge clk); #1;
      q_valid = 1'b0;
      @(negedge clk);
      check(res_valid == 1'b1, {tag, " R2 strobe"}, res_valid, 1);
      check(res_hit == exp_hit, {tag, " hit"}, res_hit, exp_hit);
      check(res_parent == exp_par, {tag, " parent"}, res_parent, exp_par);
   endtask

   // write a slot and follow its disable walk (R9); optionally inject a write mid-walk (R10)
   task automatic do_load(input int unsigned idx, input logic [W-1:0] b, input logic [W-1:0] pb,
                          input logic [W-1:0] c, input bit inject);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_idx = IW'(idx);
      wr_pin_base = b; wr_parent_base = pb; wr_count = c;
      @(posedge clk); #1;
      wr_en = 1'b0;
      m_vld[idx] = 1'b1; m_base[idx] = b; m_par[idx] = pb; m_cnt[idx] = c;
      for (int k = 0; k < int'(c); k++) begin
         @(negedge clk);
         check(dis_valid && load_busy, "R9 walk active", dis_valid, 1);
         check(dis_pin == b + W'(k), "R9 walk pin", dis_pin, b + W'(k));
         if (inject && k == 2) begin
            wr_en = 1'b1; wr_idx = IW'(3);
            wr_pin_base = 32'd500; wr_parent_base = 32'd7; wr_count = 32'd3;
         end else begin
            wr_en = 1'b0;
         end
      end
      @(negedge clk);
      wr_en = 1'b0;
      check(!dis_valid && !load_busy, "R9 walk done", dis_valid, 0);
   endtask

   initial begin
      @(posedge clk);
      repeat (200000) @(posedge clk);
      n_checks++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int s = 0; s < N; s++) begin
         m_vld[s] = 1'b0; m_base[s] = '0; m_par[s] = '0; m_cnt[s] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!res_valid && !dis_valid && !load_busy, "R1 in reset", {res_valid, dis_valid, load_busy}, 0);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(!res_valid && !dis_valid && !load_busy, "R1 after reset", {res_valid, dis_valid, load_busy}, 0);
      do_query(32'd0,  "R1 R8 empty");
      do_query(32'd12, "R8 empty");

      // slot 0: pins 10..15, write into slot 3 offered mid-walk
      do_load(0, 32'd10, 32'd100, 32'd6, 1'b1);
      do_query(32'd501, "R10 dropped write");
      do_query(32'd10, "R3 R4 low edge");
      do_query(32'd15, "R3 R4 high edge");
      do_query(32'd16, "R3 R6 past end");
      do_query(32'd9,  "R3 R6 below");

      // slot 1 overlaps slot 0 at 12..15
      do_load(1, 32'd12, 32'd200, 32'd8, 1'b0);
      do_query(32'd13, "R5 overlap");
      do_query(32'd17, "R4 slot1");

      // slot 2 reaches the top of the pin space and holds the reserved pin
      do_load(2, 32'hFFFF_FFF0, 32'd300, 32'd16, 1'b0);
      do_query(32'hFFFF_FFFF, "R7 reserved");
      do_query(32'hFFFF_FFFE, "R3 top range");
      do_query(32'hFFFF_FFF0, "R4 top base");

      // slot 3 with a parent base that wraps
      do_load(3, 32'd40, 32'hFFFF_FFFE, 32'd4, 1'b0);
      do_query(32'd41, "R4 wrap");
      do_query(32'd42, "R4 wrap zero");

      // rewrite slot 1 and give slot 3 length 0
      do_load(1, 32'd50, 32'd900, 32'd3, 1'b0);
      do_query(32'd17, "R11 old range gone");
      do_query(32'd51, "R11 new range");
      do_load(3, 32'd40, 32'd5, 32'd0, 1'b0);
      do_query(32'd40, "R3 zero length");

      for (int r = 0; r < 300; r++) begin
         logic [W-1:0] p;
         case ($urandom_range(0, 3))
            0: p = W'($urandom_range(0, 64));
            1: p = 32'hFFFF_FFE8 + W'($urandom_range(0, 23));
            2: p = $urandom();
            default: p = W'($urandom_range(36, 56));
         endcase
         do_query(p, "R3 R4 R5 random");
         if ($urandom_range(0, 3) == 0) begin
            @(negedge clk);
            check(!res_valid && !res_hit, "R2 idle", res_valid, 0);
         end
      end

      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

endmodule